// File: doc/BRIEF.md
# Serial Ninth-Bit Capture and Request Steering

This block is one control-register slice of an asynchronous serial port. A single bus address holds the ninth data bit of the last received character, the ninth data bit for the next transmitted character, and six enable bits. When the receiver moves a finished character into its data register, the block captures the ninth bit in the same clock edge. When the transmitter loads its shift register, the block hands over the transmit ninth bit in that same edge.

The block also steers requests. The receive-full condition becomes either a DMA request or a CPU interrupt, chosen by one enable. The transmit-empty condition is steered the same way by a second enable. Four error flags (overrun, noise, framing, parity) are each masked by their own enable and merged into one error interrupt. The two ninth-bit registers are deliberately left out of reset, so a reset never loses a character's ninth bit.

Top module: `sci_xbit_ctl`

## Requirements
- R1: A read at address `REG_ADDR` returns, from bit 7 down to bit 0: received ninth bit, transmit ninth bit, receive-DMA enable, transmit-DMA enable, overrun enable, noise enable, framing enable, parity enable. Any other address reads as zero. The read path is combinational.
- R2: A write to `REG_ADDR` updates bits 6 to 0 at the next clock edge. Bit 7 of the written data is ignored, and the received ninth bit keeps its value.
- R3: While `rst_n` is low, bits 5 to 0 read as zero and `tx_sh_bit8` is 0. Both ninth bits keep their values through reset. Writes and load strobes have no effect while reset is held.
- R4: With `mode9` = 1, an `rx_load` pulse stores `rx_bit8_in` as the received ninth bit.
- R5: With `mode9` = 0, an `rx_load` pulse stores `rx_bit7_in` (received data bit 7) as the received ninth bit.
- R6: With `mode9` = 1, a `tx_load` pulse copies the transmit ninth bit, as it stood before that edge, to `tx_sh_bit8`. In all other cycles `tx_sh_bit8` holds its value.
- R7: With the receive-DMA enable at 1, `rx_dma_req` follows `rx_full` and `rx_irq` is 0. With it at 0, `rx_irq` follows `rx_full` and `rx_dma_req` is 0.
- R8: The transmit-DMA enable steers `tx_empty` to `tx_dma_req` or `tx_irq` in the same way.
- R9: `err_irq` is the OR of each error flag ANDed with its enable. The flag order is `err_flags[3]` overrun, `[2]` noise, `[1]` framing, `[0]` parity. With the default `REQ_REG` = 0 the request outputs are combinational; with `REQ_REG` = 1 they are delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data |
| mode9 | input | 1 | 1 selects nine-bit characters |
| rx_load | input | 1 | Received character moves to the data register |
| rx_bit8_in | input | 1 | Ninth bit of the received character |
| rx_bit7_in | input | 1 | Bit 7 of the received character |
| tx_load | input | 1 | Transmit shift register loads |
| tx_sh_bit8 | output | 1 | Ninth bit handed to the transmit shifter |
| rx_full | input | 1 | Receive data register full |
| tx_empty | input | 1 | Transmit data register empty |
| err_flags | input | ERR_N | Overrun, noise, framing, parity flags |
| rx_dma_req | output | 1 | Receive DMA request |
| rx_irq | output | 1 | Receive CPU interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| tx_irq | output | 1 | Transmit CPU interrupt |
| err_irq | output | 1 | Merged error interrupt |

## Verification
Receive capture is driven with characters whose bit 8 and bit 7 differ, in both modes, so that a wrong bit selection shows up at once. Steering is driven through all four combinations of condition and enable on both channels, which separates a missing gate from a swapped one. Each error flag is raised alone, with its enable set and then cleared, which exposes a mis-ordered mask. A reset pulse taken while both ninth bits are 1 separates retention from clearing. Random bus traffic with a write data bit 7 that differs from the stored value shows whether that bit is ignored.

// File: rtl/sci_xbit_pkg.sv
package sci_xbit_pkg;
   localparam int XB_BUS_W     = 8;
   localparam int XB_ERR_N     = 4;
   localparam int XB_RX8_POS   = 7;
   localparam int XB_TX8_POS   = 6;
   localparam int XB_CTRL_W    = 6;

   typedef struct packed {
      logic                rx_dma_en;
      logic                tx_dma_en;
      logic [XB_ERR_N-1:0] err_ie;
   } xb_ctrl_t;
endpackage

// File: rtl/sci_xbit_reg.sv
module sci_xbit_reg
   import sci_xbit_pkg::*;
#(
   parameter int BUS_W = XB_BUS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hit,
   input  logic [BUS_W-1:0] wdata,
   output xb_ctrl_t         ctrl,
   output logic             tx_bit8
);
   localparam int CTRL_W = BUS_W - 2;

   xb_ctrl_t ctrl_q;
   logic     tx_bit8_q;
   logic     unused_wbit;

   // bit 7 of a write has no target
   assign unused_wbit = wdata[XB_RX8_POS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_hit) begin
         ctrl_q <= xb_ctrl_t'(wdata[CTRL_W-1:0]);
      end
   end

   // no reset on the ninth bit; updates are held off while reset is low
   always_ff @(posedge clk) begin
      if (rst_n && wr_hit) begin
         tx_bit8_q <= wdata[XB_TX8_POS];
      end
   end

   assign ctrl    = ctrl_q;
   assign tx_bit8 = tx_bit8_q;
endmodule

// File: rtl/sci_xbit_nine.sv
module sci_xbit_nine (
   input  logic clk,
   input  logic rst_n,
   input  logic mode9,
   input  logic rx_load,
   input  logic rx_bit8_in,
   input  logic rx_bit7_in,
   input  logic tx_load,
   input  logic tx_bit8,
   output logic rx_bit8,
   output logic tx_sh_bit8
);
   logic rx_bit8_q;
   logic sh_bit8_q;
   logic rx_pick;

   assign rx_pick = mode9 ? rx_bit8_in : rx_bit7_in;

   // received ninth bit survives reset
   always_ff @(posedge clk) begin
      if (rst_n && rx_load) begin
         rx_bit8_q <= rx_pick;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_bit8_q <= 1'b0;
      end else if (tx_load && mode9) begin
         sh_bit8_q <= tx_bit8;
      end
   end

   assign rx_bit8    = rx_bit8_q;
   assign tx_sh_bit8 = sh_bit8_q;
endmodule

// File: rtl/sci_xbit_steer.sv
module sci_xbit_steer
   import sci_xbit_pkg::*;
#(
   parameter int ERR_N   = XB_ERR_N,
   parameter bit REQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  xb_ctrl_t         ctrl,
   input  logic             rx_full,
   input  logic             tx_empty,
   input  logic [ERR_N-1:0] err_flags,
   output logic             rx_dma_req,
   output logic             rx_irq,
   output logic             tx_dma_req,
   output logic             tx_irq,
   output logic             err_irq
);
   localparam int REQ_N = 5;

   logic [REQ_N-1:0] req_nxt;
   logic [REQ_N-1:0] req_out;
   logic [ERR_N-1:0] err_masked;

   assign err_masked = err_flags & ctrl.err_ie;

   always_comb begin
      req_nxt[4] = rx_full  &  ctrl.rx_dma_en;
      req_nxt[3] = rx_full  & ~ctrl.rx_dma_en;
      req_nxt[2] = tx_empty &  ctrl.tx_dma_en;
      req_nxt[1] = tx_empty & ~ctrl.tx_dma_en;
      req_nxt[0] = |err_masked;
   end

   generate
      if (REQ_REG) begin : g_flop
         logic [REQ_N-1:0] req_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               req_q <= '0;
            end else begin
               req_q <= req_nxt;
            end
         end
         assign req_out = req_q;
      end else begin : g_wire
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign req_out    = req_nxt;
      end
   endgenerate

   assign rx_dma_req = req_out[4];
   assign rx_irq     = req_out[3];
   assign tx_dma_req = req_out[2];
   assign tx_irq     = req_out[1];
   assign err_irq    = req_out[0];
endmodule

// File: rtl/sci_xbit_ctl.sv
module sci_xbit_ctl
   import sci_xbit_pkg::*;
#(
   parameter int ADDR_W   = 3,
   parameter int REG_ADDR = 5,
   parameter int BUS_W    = XB_BUS_W,
   parameter int ERR_N    = XB_ERR_N,
   parameter bit REQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              mode9,
   input  logic              rx_load,
   input  logic              rx_bit8_in,
   input  logic              rx_bit7_in,
   input  logic              tx_load,
   output logic              tx_sh_bit8,
   input  logic              rx_full,
   input  logic              tx_empty,
   input  logic [ERR_N-1:0]  err_flags,
   output logic              rx_dma_req,
   output logic              rx_irq,
   output logic              tx_dma_req,
   output logic              tx_irq,
   output logic              err_irq
);
   localparam logic [ADDR_W-1:0] REG_SEL = ADDR_W'(REG_ADDR);

   generate
      if (BUS_W != XB_BUS_W) begin : g_bad_bus
         $error("sci_xbit_ctl: BUS_W must be %0d", XB_BUS_W);
      end
      if (ERR_N != XB_ERR_N) begin : g_bad_err
         $error("sci_xbit_ctl: ERR_N must be %0d", XB_ERR_N);
      end
      if (ADDR_W < 1 || REG_ADDR < 0 || REG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("sci_xbit_ctl: REG_ADDR outside the address range");
      end
   endgenerate

   logic     addr_hit;
   logic     wr_hit;
   xb_ctrl_t ctrl_q;
   logic     tx_bit8_q;
   logic     rx_bit8_q;

   assign addr_hit = (bus_addr == REG_SEL);
   assign wr_hit   = addr_hit & bus_wr;

   sci_xbit_reg #(.BUS_W(BUS_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (wr_hit),
      .wdata   (bus_wdata),
      .ctrl    (ctrl_q),
      .tx_bit8 (tx_bit8_q)
   );

   sci_xbit_nine u_nine (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode9      (mode9),
      .rx_load    (rx_load),
      .rx_bit8_in (rx_bit8_in),
      .rx_bit7_in (rx_bit7_in),
      .tx_load    (tx_load),
      .tx_bit8    (tx_bit8_q),
      .rx_bit8    (rx_bit8_q),
      .tx_sh_bit8 (tx_sh_bit8)
   );

   sci_xbit_steer #(.ERR_N(ERR_N), .REQ_REG(REQ_REG)) u_steer (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl       (ctrl_q),
      .rx_full    (rx_full),
      .tx_empty   (tx_empty),
      .err_flags  (err_flags),
      .rx_dma_req (rx_dma_req),
      .rx_irq     (rx_irq),
      .tx_dma_req (tx_dma_req),
      .tx_irq     (tx_irq),
      .err_irq    (err_irq)
   );

   assign bus_rdata = addr_hit ? {rx_bit8_q, tx_bit8_q, ctrl_q} : '0;
endmodule

// File: rtl/sci_xbit_chk.sv
module sci_xbit_chk
   import sci_xbit_pkg::*;
#(
   parameter int BUS_W   = XB_BUS_W,
   parameter int ERR_N   = XB_ERR_N,
   parameter bit REQ_REG = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_hit,
   input logic [BUS_W-1:0] bus_wdata,
   input logic             mode9,
   input logic             rx_load,
   input logic             rx_bit8_in,
   input logic             rx_bit7_in,
   input logic             tx_load,
   input logic             tx_sh_bit8,
   input xb_ctrl_t         ctrl,
   input logic             rx_bit8,
   input logic             tx_bit8,
   input logic             rx_full,
   input logic             tx_empty,
   input logic [ERR_N-1:0] err_flags,
   input logic             rx_dma_req,
   input logic             rx_irq,
   input logic             tx_dma_req,
   input logic             tx_irq,
   input logic             err_irq
);
   logic seen = 1'b0;

   always_ff @(posedge clk) seen <= 1'b1;

   // R7
   rx_route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_irq && rx_dma_req));

   // R8
   tx_route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_irq && tx_dma_req));

   // R4
   rx_cap9_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_load && mode9) |=> (rx_bit8 == $past(rx_bit8_in)));

   // R5
   rx_cap8_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_load && !mode9) |=> (rx_bit8 == $past(rx_bit7_in)));

   // R2
   rx8_wr_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !rx_load) |=> $stable(rx_bit8));

   // R2
   tx8_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (tx_bit8 == $past(bus_wdata[XB_TX8_POS])));

   // R6
   tx_hand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_load && mode9) |=> (tx_sh_bit8 == $past(tx_bit8)));

   // R6
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_load && mode9) |=> $stable(tx_sh_bit8));

   // R3
   keep_over_rst_chk: assert property (@(posedge clk)
      (seen && !rst_n) |=> ($stable(rx_bit8) && $stable(tx_bit8)));

   // R3
   ctrl_clr_chk: assert property (@(posedge clk)
      (seen && !rst_n) |-> (ctrl == '0 && !tx_sh_bit8));

   generate
      if (REQ_REG) begin : g_late
         // R9
         err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((err_flags & ctrl.err_ie) == '0) |=> !err_irq);
         // R7
         rx_dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!rx_full || !ctrl.rx_dma_en) |=> !rx_dma_req);
         // R8
         tx_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!tx_empty || ctrl.tx_dma_en) |=> !tx_irq);
      end else begin : g_now
         // R9
         err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((err_flags & ctrl.err_ie) == '0) |-> !err_irq);
         // R7
         rx_dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rx_dma_req |-> (rx_full && ctrl.rx_dma_en));
         // R8
         tx_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tx_irq |-> (tx_empty && !ctrl.tx_dma_en));
      end
   endgenerate
endmodule

bind sci_xbit_ctl sci_xbit_chk #(.BUS_W(BUS_W), .ERR_N(ERR_N), .REQ_REG(REQ_REG)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_hit     (wr_hit),
   .bus_wdata  (bus_wdata),
   .mode9      (mode9),
   .rx_load    (rx_load),
   .rx_bit8_in (rx_bit8_in),
   .rx_bit7_in (rx_bit7_in),
   .tx_load    (tx_load),
   .tx_sh_bit8 (tx_sh_bit8),
   .ctrl       (ctrl_q),
   .rx_bit8    (rx_bit8_q),
   .tx_bit8    (tx_bit8_q),
   .rx_full    (rx_full),
   .tx_empty   (tx_empty),
   .err_flags  (err_flags),
   .rx_dma_req (rx_dma_req),
   .rx_irq     (rx_irq),
   .tx_dma_req (tx_dma_req),
   .tx_irq     (tx_irq),
   .err_irq    (err_irq)
);

// File: tb/sci_xbit_ctl_bench.sv
`timescale 1ns/1ps
module sci_xbit_ctl_bench;
   localparam int ADDR_W = 3;
   localparam int REG_A  = 5;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [ADDR_W-1:0] bus_addr;
   logic              bus_wr;
   logic [7:0]        bus_wdata;
   logic [7:0]        bus_rdata;
   logic              mode9, rx_load, rx_bit8_in, rx_bit7_in, tx_load, tx_sh_bit8;
   logic              rx_full, tx_empty;
   logic [3:0]        err_flags;
   logic              rx_dma_req, rx_irq, tx_dma_req, tx_irq, err_irq;

   always #2 clk = ~clk;

   sci_xbit_ctl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_A)) u_sci_xbit_ctl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode9(mode9),
      .rx_load(rx_load), .rx_bit8_in(rx_bit8_in), .rx_bit7_in(rx_bit7_in),
      .tx_load(tx_load), .tx_sh_bit8(tx_sh_bit8), .rx_full(rx_full),
      .tx_empty(tx_empty), .err_flags(err_flags), .rx_dma_req(rx_dma_req),
      .rx_irq(rx_irq), .tx_dma_req(tx_dma_req), .tx_irq(tx_irq), .err_irq(err_irq)
   );

   // stimulus values
   logic              s_rst_n = 1'b0;
   logic [ADDR_W-1:0] s_addr = '0;
   logic              s_wr = 1'b0;
   logic [7:0]        s_wdata = '0;
   logic              s_mode9 = 1'b0, s_rx_load = 1'b0, s_b8 = 1'b0, s_b7 = 1'b0, s_tx_load = 1'b0;
   logic              s_rx_full = 1'b0, s_tx_empty = 1'b0;
   logic [3:0]        s_err = '0;

   // reference state
   logic       m_rx8 = 1'b0, m_tx8 = 1'b0, m_sh = 1'b0, known = 1'b0;
   logic [5:0] m_ctrl = '0;

   int  n_chk = 0;
   int  n_fail = 0;
   logic done = 1'b0;

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %02h expected %02h", req, $time, act, exp);
      end
   endtask

   task automatic idle();
      s_wr = 1'b0; s_rx_load = 1'b0; s_tx_load = 1'b0;
   endtask

   task automatic cyc();
      logic [7:0] exp_rd;
      logic [7:0] mask;
      @(negedge clk);
      rst_n = s_rst_n; bus_addr = s_addr; bus_wr = s_wr; bus_wdata = s_wdata;
      mode9 = s_mode9; rx_load = s_rx_load; rx_bit8_in = s_b8; rx_bit7_in = s_b7;
      tx_load = s_tx_load; rx_full = s_rx_full; tx_empty = s_tx_empty; err_flags = s_err;
      if (!s_rst_n) begin
         m_ctrl = '0; m_sh = 1'b0;
      end
      #1;
      mask   = known ? 8'hFF : 8'h3F;
      exp_rd = (s_addr == ADDR_W'(REG_A)) ? {m_rx8, m_tx8, m_ctrl} : 8'h00;
      check("R1 R2 R3 R4 R5 register read", bus_rdata & mask, exp_rd & mask);
      check("R7 rx dma request", {7'b0, rx_dma_req}, {7'b0, s_rx_full & m_ctrl[5]});
      check("R7 rx interrupt", {7'b0, rx_irq}, {7'b0, s_rx_full & ~m_ctrl[5]});
      check("R8 tx dma request", {7'b0, tx_dma_req}, {7'b0, s_tx_empty & m_ctrl[4]});
      check("R8 tx interrupt", {7'b0, tx_irq}, {7'b0, s_tx_empty & ~m_ctrl[4]});
      check("R9 error interrupt", {7'b0, err_irq}, {7'b0, |(s_err & m_ctrl[3:0])});
      if (known) check("R6 R3 shifter ninth bit", {7'b0, tx_sh_bit8}, {7'b0, m_sh});
      @(posedge clk);
      if (s_rst_n) begin
         if (s_tx_load && s_mode9) m_sh = m_tx8;
         if (s_rx_load) m_rx8 = s_mode9 ? s_b8 : s_b7;
         if (s_wr && s_addr == ADDR_W'(REG_A)) begin
            m_tx8  = s_wdata[6];
            m_ctrl = s_wdata[5:0];
         end
      end
   endtask

   task automatic wr_reg(input logic [7:0] d);
      idle(); s_addr = ADDR_W'(REG_A); s_wr = 1'b1; s_wdata = d; cyc(); idle();
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      // reset state of the enable bits (R3)
      repeat (3) cyc();
      s_rst_n = 1'b1;
      s_addr = ADDR_W'(REG_A);
      cyc();
      // establish known ninth bits
      s_wr = 1'b1; s_wdata = 8'h00; s_rx_load = 1'b1; s_mode9 = 1'b1; s_b8 = 1'b0;
      cyc(); idle();
      known = 1'b1;
      m_sh = 1'b0;
      cyc();
      // R2: bit 7 of a write ignored
      wr_reg(8'hFF); cyc();
      wr_reg(8'h80); cyc();
      // R4: nine-bit capture, bit 8 and bit 7 differ
      s_mode9 = 1'b1; s_rx_load = 1'b1; s_b8 = 1'b1; s_b7 = 1'b0; cyc(); idle(); cyc();
      s_rx_load = 1'b1; s_b8 = 1'b0; s_b7 = 1'b1; cyc(); idle(); cyc();
      // R5: eight-bit mirror of bit 7
      s_mode9 = 1'b0; s_rx_load = 1'b1; s_b8 = 1'b0; s_b7 = 1'b1; cyc(); idle(); cyc();
      s_rx_load = 1'b1; s_b8 = 1'b1; s_b7 = 1'b0; cyc(); idle(); cyc();
      // R6: hand-off in nine-bit mode, hold in eight-bit mode
      wr_reg(8'h40);
      s_mode9 = 1'b1; s_tx_load = 1'b1; cyc(); idle(); cyc();
      wr_reg(8'h00);
      s_mode9 = 1'b0; s_tx_load = 1'b1; cyc(); idle(); cyc();
      // R6: load and write in one cycle hands over the old value
      s_mode9 = 1'b1; s_tx_load = 1'b1; s_wr = 1'b1; s_wdata = 8'h40; cyc(); idle(); cyc();
      // R3: reset keeps both ninth bits, clears enables
      s_rx_load = 1'b1; s_b8 = 1'b1; cyc(); idle();
      wr_reg(8'h7F); cyc();
      s_rst_n = 1'b0; s_wr = 1'b1; s_wdata = 8'h00; s_rx_load = 1'b1; s_b8 = 1'b0;
      cyc(); cyc(); idle();
      s_rst_n = 1'b1; cyc(); cyc();
      // R7 R8: all condition/enable combinations
      for (int e = 0; e < 4; e++) begin
         wr_reg({2'b00, e[1:0], 4'h0});
         for (int c = 0; c < 4; c++) begin
            s_rx_full = c[0]; s_tx_empty = c[1]; cyc();
         end
      end
      s_rx_full = 1'b0; s_tx_empty = 1'b0;
      // R9: each flag alone, enabled then masked
      for (int f = 0; f < 4; f++) begin
         wr_reg(8'h0F); s_err = 4'(1 << f); cyc();
         wr_reg(8'h0F & ~8'(1 << f)); cyc();
         s_err = 4'h0; cyc();
      end
      // random traffic across all requirements
      for (int i = 0; i < 3000; i++) begin
         s_addr     = ADDR_W'($urandom_range(0, (1 << ADDR_W) - 1));
         s_wr       = ($urandom_range(0, 3) == 0);
         s_wdata    = 8'($urandom);
         s_mode9    = 1'($urandom);
         s_rx_load  = ($urandom_range(0, 3) == 0);
         s_b8       = 1'($urandom);
         s_b7       = 1'($urandom);
         s_tx_load  = ($urandom_range(0, 3) == 0);
         s_rx_full  = 1'($urandom);
         s_tx_empty = 1'($urandom);
         s_err      = 4'($urandom);
         s_rst_n    = ($urandom_range(0, 99) != 0);
         if (i % 4 == 0) s_addr = ADDR_W'(REG_A);
         cyc();
      end
      s_rst_n = 1'b1; idle(); cyc();
      done = 1'b1;
      summary();
      $finish;
   end
endmodule